// File: doc/BRIEF.md
# Double-word pixel fetch serializer

This block sits between a graphics controller's video memory data bus and the colour path of a display. The controller is set up to skip every other address, so each memory cycle it starts must return two adjacent 16-bit words. The block captures both words through one 16-bit holding register and serializes them into eight 4-bit colour values, one per pixel clock.

Everything runs on the pixel clock, which is four times the controller clock. A one-cycle phase marker shows where each controller clock period starts, so the block can keep a phase counter. A memory-cycle strobe, sampled at phase 0, starts a fetch. The first word is captured at phase 1. It moves into the shift stage at phase 2, which frees the holding register for the second word at phase 3. An active-low load strobe is brought out so that the external memory glue can drive the bus in step with the captures.

A memory cycle takes two controller periods, eight pixel clocks. If no fetch is in progress, the colour output is 0.

Top module: `dword_pix_serializer`

## Requirements
- R1: The pixel clock in which the phase marker is high is phase 0. The phase advances by one per pixel clock, modulo 4. It keeps counting when the marker is absent. Reset sets the phase so that the first clock after reset is phase 0.
- R2: The memory-cycle strobe is sampled only at phase 0. An accepted strobe starts a memory cycle that spans two controller periods. A strobe at phase 0 of the period right after an accepted one is ignored.
- R3: The load strobe is low (0) during phase 1 and phase 3 of the first period of an accepted memory cycle. It is high (1) in every other cycle.
- R4: The holding register takes the data bus at the end of phase 1 (first word) and at the end of phase 3 (second word). Bus values at other phases, or in periods without an accepted strobe, have no effect on the output.
- R5: The shift stage loads the first word at the end of phase 2 of the first period. It loads the second word at the end of phase 2 of the second period. The colour output is registered.
- R6: Each word is sent most significant nibble first: bits 15:12, then 11:8, then 7:4, then 3:0. The eight nibbles of a memory cycle appear in eight consecutive pixel clocks, starting at phase 3 of the first period.
- R7: Accepted strobes in every other controller period produce an unbroken colour stream, with no idle clock between words or between memory cycles.
- R8: In any four-clock window that has no word, from phase 3 to the next phase 2, the colour output is 0.
- R9: A synchronous active-high reset clears the phase counter, the holding register and the shift stage, and drives the load strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_tick_i | input | 1 | Phase marker, high for the pixel clock that starts a controller period |
| mem_cyc_i | input | 1 | Memory-cycle strobe, sampled at phase 0 |
| vram_data_i | input | 16 | Video memory data bus |
| pix_o | output | 4 | Colour value for the current pixel clock |
| hold_ld_n_o | output | 1 | Active-low holding-register load strobe |

## Verification
The second-word capture into the holding register (phase 3) falls in the same clock as the first nibble of the first word leaving the shift stage. A wrong hand-off therefore shows up either as a corrupted first word or as a lost second word. The bench provokes this with strobes in every other period and with decoy values on the data bus at every non-capture phase. It compares every output nibble and every load-strobe level against a schedule it computes from the strobe pattern. Further sweeps use a strobe in every period, which exercises the ignored strobe, use sparse strobes with idle gaps, and drop most phase markers.

// File: rtl/dwps_pkg.sv
package dwps_pkg;

  // Position of the current controller period inside a memory cycle
  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_FIRST  = 2'd1,
    SLOT_SECOND = 2'd2
  } slot_e;

  // Phase at which each event happens within a controller period
  localparam int PH_START   = 0;
  localparam int PH_CAP_A   = 1;
  localparam int PH_SHIFT   = 2;

  // Next state of the memory-cycle tracker, evaluated at phase 0
  function automatic slot_e slot_step(slot_e cur, logic strobe);
    slot_e nxt;
    case (cur)
      SLOT_FIRST: nxt = SLOT_SECOND;
      default:    nxt = strobe ? SLOT_FIRST : SLOT_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/dwps_phase.sv
module dwps_phase #(
  parameter int RATIO = 4,
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  output logic [PW-1:0] phase_o,
  output logic          at_start_o,
  output logic          at_cap_a_o,
  output logic          at_shift_o,
  output logic          at_cap_b_o
);
  import dwps_pkg::*;

  localparam logic [PW-1:0] PH_LAST = PW'(RATIO - 1);

  function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] p);
    return (p == PH_LAST) ? '0 : p + 1'b1;
  endfunction

  logic [PW-1:0] ph_q;
  logic [PW-1:0] cur;

  // The marker forces phase 0; otherwise the counter free-runs
  assign cur = tick_i ? '0 : ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= wrap_inc(cur);
  end

  assign phase_o    = cur;
  assign at_start_o = (cur == PW'(PH_START));
  assign at_cap_a_o = (cur == PW'(PH_CAP_A));
  assign at_shift_o = (cur == PW'(PH_SHIFT));
  assign at_cap_b_o = (cur == PH_LAST);

  // R1: with no marker, the phase steps by exactly one
  p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> (tick_i || phase_o == wrap_inc($past(phase_o))));

endmodule

// File: rtl/dwps_capture.sv
module dwps_capture #(
  parameter int WORD_W = 16,
  parameter int RATIO  = 4,
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW-1:0]     phase_i,
  input  logic              at_start_i,
  input  logic              at_cap_a_i,
  input  logic              at_cap_b_i,
  input  logic              strobe_i,
  input  logic [WORD_W-1:0] data_i,
  output dwps_pkg::slot_e   slot_o,
  output logic              hold_ld_n_o,
  output logic [WORD_W-1:0] hold_o
);
  import dwps_pkg::*;

  slot_e             slot_q;
  logic              cap_en;
  logic [WORD_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)             slot_q <= SLOT_IDLE;
    else if (at_start_i) slot_q <= slot_step(slot_q, strobe_i);
  end

  // Both captures fall in the first period of an accepted memory cycle
  assign cap_en = !rst && (slot_q == SLOT_FIRST) && (at_cap_a_i || at_cap_b_i);

  always_ff @(posedge clk) begin
    if (rst)         hold_q <= '0;
    else if (cap_en) hold_q <= data_i;
  end

  assign slot_o      = slot_q;
  assign hold_ld_n_o = !cap_en;
  assign hold_o      = hold_q;

  // R3: the load strobe goes low only at phase 1 or the last phase
  p_ld_phase_r3: assert property (@(posedge clk) disable iff (rst)
    !hold_ld_n_o |-> (phase_i == PW'(PH_CAP_A) || phase_i == PW'(RATIO - 1)));

  // R3: a first-word load is followed by the second-word load two clocks later
  p_ld_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (!hold_ld_n_o && at_cap_a_i) |-> ##2 !hold_ld_n_o);

  // R2: nothing is captured in the second period of a memory cycle
  p_second_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (slot_q == SLOT_SECOND) |-> hold_ld_n_o);

endmodule

// File: rtl/dwps_shift.sv
module dwps_shift #(
  parameter int WORD_W = 16,
  parameter int PIX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              fill_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [PIX_W-1:0]  pix_o
);
  localparam int NPIX = WORD_W / PIX_W;

  logic [WORD_W-1:0] sh_q;

  function automatic logic [WORD_W-1:0] advance(logic [WORD_W-1:0] w);
    return w << PIX_W;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)         sh_q <= '0;
    else if (load_i) sh_q <= fill_i ? word_i : '0;
    else             sh_q <= advance(sh_q);
  end

  // The first pixel of a word is its top nibble
  assign pix_o = sh_q[WORD_W-1 -: PIX_W];

  generate
    if (NPIX > 1) begin : g_order
      // R6: between loads the next lower nibble comes out
      p_shift_order_r6: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> (pix_o == $past(sh_q[WORD_W-PIX_W-1 -: PIX_W])));
    end
  endgenerate

  // R8: an empty load slot gives colour 0
  p_zero_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (load_i && !fill_i) |=> (pix_o == '0));

endmodule

// File: rtl/dword_pix_serializer.sv
module dword_pix_serializer #(
  parameter int WORD_W = 16,
  parameter int PIX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_tick_i,
  input  logic              mem_cyc_i,
  input  logic [WORD_W-1:0] vram_data_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              hold_ld_n_o
);
  import dwps_pkg::*;

  localparam int RATIO = WORD_W / PIX_W;
  localparam int PW    = (RATIO > 1) ? $clog2(RATIO) : 1;

  // Named internal events
  logic [PW-1:0]     phase;
  logic              at_start, at_cap_a, at_shift, at_cap_b;
  slot_e             slot;
  logic [WORD_W-1:0] hold_word;
  logic              shift_load, shift_fill;

  dwps_phase #(.RATIO(RATIO)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (ctl_tick_i),
    .phase_o    (phase),
    .at_start_o (at_start),
    .at_cap_a_o (at_cap_a),
    .at_shift_o (at_shift),
    .at_cap_b_o (at_cap_b)
  );

  dwps_capture #(.WORD_W(WORD_W), .RATIO(RATIO)) u_capture (
    .clk         (clk),
    .rst         (rst),
    .phase_i     (phase),
    .at_start_i  (at_start),
    .at_cap_a_i  (at_cap_a),
    .at_cap_b_i  (at_cap_b),
    .strobe_i    (mem_cyc_i),
    .data_i      (vram_data_i),
    .slot_o      (slot),
    .hold_ld_n_o (hold_ld_n_o),
    .hold_o      (hold_word)
  );

  // The shift stage reloads once per controller period; it holds a word in either period of a cycle
  assign shift_load = at_shift;
  assign shift_fill = (slot != SLOT_IDLE);

  dwps_shift #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load_i (shift_load),
    .fill_i (shift_fill),
    .word_i (hold_word),
    .pix_o  (pix_o)
  );

  // R5: the word captured at phase 1 appears at the output two clocks later, top nibble first
  p_handoff_r5: assert property (@(posedge clk) disable iff (rst)
    (!hold_ld_n_o && at_cap_a) |-> ##2 (pix_o == $past(vram_data_i[WORD_W-1 -: PIX_W], 2)));

  // R9: one clock after reset the output is idle and the load strobe is high
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;
  always_ff @(posedge clk) begin
    if (rst_d) begin
      p_reset_idle_r9: assert (pix_o == '0 && hold_ld_n_o);
    end
  end

endmodule

// File: tb/sim_dword_pix_serializer.sv
`timescale 1ns/1ps
module sim_dword_pix_serializer;

  localparam int MAXC = 1024;
  localparam int NP   = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        mcyc = 1'b0;
  logic [15:0] data = '0;
  logic [3:0]  pix;
  logic        ld_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [3:0] exp_pix [MAXC];
  bit         exp_ld  [MAXC];
  bit         exp_src [MAXC];

  always #2.5 clk = ~clk;

  dword_pix_serializer u0 (
    .clk         (clk),
    .rst         (rst),
    .ctl_tick_i  (tick),
    .mem_cyc_i   (mcyc),
    .vram_data_i (data),
    .pix_o       (pix),
    .hold_ld_n_o (ld_n)
  );

  function automatic logic [15:0] wgen(int mode, int p, int sel);
    int v;
    v = p * 40503 + sel * 12345 + mode * 777 + (p << 9);
    return 16'(v ^ (v >> 5));
  endfunction

  // R2 strobe patterns per mode
  function automatic bit strobe_at(int mode, int p);
    case (mode)
      0: return (p % 2) == 0;
      1: return 1'b1;
      2: return (p % 5) == 0 || (p % 5) == 1;
      default: return (p % 2) == 0;
    endcase
  endfunction

  // R1: mode 3 drops most phase markers
  function automatic bit marker_at(int mode, int p);
    return (mode == 3) ? ((p % 8) == 0) : 1'b1;
  endfunction

  task automatic chk(string tag, int t, int got, int expv);
    n_cmp++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got %0h expected %0h", tag, t, got, expv);
    end
  endtask

  // R9: reset clears output and releases the load strobe
  task automatic do_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rst = 1'b1; tick = 1'b0; mcyc = 1'b0; data = 16'hFFFF;
      if (i > 0) begin
        #1;
        chk("R9 reset pix", i, pix, 0);
        chk("R9 reset ld_n", i, ld_n, 1);
      end
    end
  endtask

  task automatic run_mode(int mode);
    bit acc_prev;
    bit acc;
    logic [15:0] wa, wb;
    for (int t = 0; t < MAXC; t++) begin
      exp_pix[t] = '0; exp_ld[t] = 1'b1; exp_src[t] = 1'b0;
    end
    // Expected schedule from R2, R3, R5, R6
    acc_prev = 1'b0;
    for (int p = 0; p < NP; p++) begin
      acc = strobe_at(mode, p) && !acc_prev;
      if (acc) begin
        wa = wgen(mode, p, 0);
        wb = wgen(mode, p, 1);
        exp_ld[4*p+1] = 1'b0;
        exp_ld[4*p+3] = 1'b0;
        for (int i = 0; i < 4; i++) begin
          exp_pix[4*p+3+i] = wa[15-4*i -: 4];
          exp_pix[4*p+7+i] = wb[15-4*i -: 4];
          exp_src[4*p+3+i] = 1'b1;
          exp_src[4*p+7+i] = 1'b1;
        end
      end
      acc_prev = acc;
    end
    do_reset();
    for (int t = 0; t < 4*NP; t++) begin
      int p;
      int ph;
      p  = t / 4;
      ph = t % 4;
      @(negedge clk);
      rst  = 1'b0;
      tick = (ph == 0) && marker_at(mode, p);
      mcyc = (ph == 0) && strobe_at(mode, p);
      // R4: decoy values on the bus outside the capture phases
      case (ph)
        1:       data = wgen(mode, p, 0);
        3:       data = wgen(mode, p, 1);
        default: data = ~wgen(mode, p, 0) ^ 16'(t);
      endcase
      #1;
      if (t == 0) chk("R9 first cycle pix", t, pix, 0);
      if (exp_src[t])
        chk((mode == 0) ? "R7 stream nibble" : "R6 nibble order", t, pix, exp_pix[t]);
      else
        chk("R8 idle zero", t, pix, exp_pix[t]);
      chk("R3 load strobe", t, ld_n, exp_ld[t]);
    end
  endtask

  initial begin
    run_mode(0);  // R7 continuous fetches, R5 hand-off timing
    run_mode(1);  // R2 strobe in every period, odd ones ignored
    run_mode(2);  // R8 gaps, R4 bus ignored when idle
    run_mode(3);  // R1 free-running phase without markers
    do_reset();   // R9 reset during a running stream
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule